// File: doc/BRIEF.md
# Counter Overflow Flag Register

This block keeps one sticky flag per performance counter in a 64-bit status word. A cycle counter, up to 31 event counters and an optional instruction counter each report their wraps as single-cycle pulses: one pulse when the low 32 bits wrap and one when the whole 64-bit value wraps. Run-time mode inputs decide, for each class of counter, which of the two pulses counts as an overflow. When the chosen pulse arrives, the block sets the matching flag and holds it until software clears it.

Software reaches the flags through a simple one-cycle register bus that offers three views of the same word. The plain view is read-only. The set view ORs written ones into the flags. The clear view drops the flags where ones are written. Flags for event counters that are not built, or that lie above a restricted boundary for a caller without full privilege, read as zero and cannot be written. If a power, lock or permission input blocks the access, the bus returns an error and leaves the flags alone.

Top module: `ovf_flag_reg`

## Requirements
- R1: After a synchronous active-low reset, every flag is 0, so the first read returns 64'h0.
- R2: Bit 31 holds the cycle counter flag. Bit m (m from 0 to NUM_EVT-1) holds the event counter m flag. Bit 32 holds the instruction counter flag when HAS_INSTR=1. Bits 63:33 always read 0.
- R3: With cyc_long=0, only cyc_wrap32 sets bit 31. With cyc_long=1, only cyc_wrap64 sets it.
- R4: Event counters with an index below evt_split use evt_long_lo to choose the pulse. Those at or above evt_split use evt_long_hi. A control at 0 selects evt_wrap32 and a control at 1 selects evt_wrap64.
- R5: The instruction counter flag (bit 32) is set by ins_wrap64.
- R6: A set flag stays set through any number of cycles and reads until a clear-view write with a one in that bit.
- R7: bus_view 2'b01 ORs bus_wdata into the flags. bus_view 2'b10 clears the flags where bus_wdata is 1. A write with bus_view 2'b00 or 2'b11 changes nothing.
- R8: If an overflow and a clear-view write hit the same bit in the same cycle, the flag ends up set.
- R9: Event flag bits at index NUM_EVT and above (up to bit 30) read 0, ignore writes and are never set.
- R10: When rr_en=1 and acc_secure=0, event flags with index at or above rr_bound read 0 and ignore writes, but keep their stored value. A secure access sees and writes them normally.
- R11: An access is in error when core_off, dbl_lock or ext_block is 1, or when os_lock=1 and os_override=0. An errored access returns rsp_err=1 and rsp_rdata=0 and writes nothing. Overflows still set flags while this happens.
- R12: An access in cycle t gives rsp_vld=1 in cycle t+1. rsp_rdata shows the visible flags as they were before that access's own write and before same-cycle overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_long | input | 1 | Cycle counter mode: 1 selects the 64-bit wrap |
| evt_long_lo | input | 1 | Event mode for counters below evt_split |
| evt_long_hi | input | 1 | Event mode for counters at or above evt_split |
| evt_split | input | 5 | First event index governed by evt_long_hi |
| cyc_wrap32 | input | 1 | Cycle counter low-32-bit wrap pulse |
| cyc_wrap64 | input | 1 | Cycle counter full 64-bit wrap pulse |
| evt_wrap32 | input | NUM_EVT | Per event counter low-32-bit wrap pulses |
| evt_wrap64 | input | NUM_EVT | Per event counter 64-bit wrap pulses |
| ins_wrap64 | input | 1 | Instruction counter wrap pulse |
| rr_en | input | 1 | Restricted counter range in force |
| rr_bound | input | 5 | First event index hidden from non-secure callers |
| acc_secure | input | 1 | Current access has full privilege |
| core_off | input | 1 | Core powered down (blocks access) |
| dbl_lock | input | 1 | Double lock active (blocks access) |
| ext_block | input | 1 | External access disallowed (blocks access) |
| os_lock | input | 1 | OS lock set |
| os_override | input | 1 | OS lock bypass permitted |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | Access is a write |
| bus_view | input | 2 | 00 read, 01 set, 10 clear, 11 reserved |
| bus_wdata | input | 64 | Write data |
| rsp_vld | output | 1 | Response valid |
| rsp_err | output | 1 | Response is an error |
| rsp_rdata | output | 64 | Read data |

## Verification
First, each counter class receives the wrong-width pulse alone and then the right-width pulse alone under both mode settings. This tells pulse selection apart from plain OR-ing of the two pulses. Event counters are also pulsed all at once with a split in the middle, which exposes a swapped or off-by-one split compare. Writes of all ones through every view show which bits exist and which views may change them. The same restricted-range clear is then read back by a secure and a non-secure caller, which separates hiding a bit from erasing it. Finally, a clear and an overflow on one bit in one cycle, plus blocked writes under each error cause, cover the ordering and gating rules.

// File: rtl/ovf_pkg.sv
// Package: shared bit positions and bus view encoding for the overflow flag register.
package ovf_pkg;
    localparam int REG_W   = 64;
    localparam int CYC_BIT = 31;
    localparam int INS_BIT = 32;
    localparam int MAX_EVT = 31;
    localparam int IDX_W   = 5;

    typedef enum logic [1:0] {
        VIEW_READ = 2'b00,
        VIEW_SET  = 2'b01,
        VIEW_CLR  = 2'b10,
        VIEW_RSVD = 2'b11
    } view_e;
endpackage

// File: rtl/ovf_detect.sv
// Module: ovf_detect
// Chooses, per counter, which wrap pulse is an overflow according to the
// mode inputs, and places the result at that counter's flag position.
// Assumes wrap pulses last one cycle and NUM_EVT is at most 31.
module ovf_detect
    import ovf_pkg::*;
#(
    parameter int NUM_EVT   = 6,
    parameter int HAS_INSTR = 1
) (
    input  logic               cyc_long,
    input  logic               evt_long_lo,
    input  logic               evt_long_hi,
    input  logic [IDX_W-1:0]   evt_split,
    input  logic               cyc_wrap32,
    input  logic               cyc_wrap64,
    input  logic [NUM_EVT-1:0] evt_wrap32,
    input  logic [NUM_EVT-1:0] evt_wrap64,
    input  logic               ins_wrap64,
    output logic [REG_W-1:0]   ovf_vec
);
    logic [NUM_EVT-1:0] evt_ovf;

    // Per event counter: choose the mode by range, then the pulse by mode.
    for (genvar m = 0; m < NUM_EVT; m++) begin : g_evt
        logic use_long;
        assign use_long   = (IDX_W'(m) >= evt_split) ? evt_long_hi : evt_long_lo;
        assign evt_ovf[m] = use_long ? evt_wrap64[m] : evt_wrap32[m];
    end

    // Assemble the overflow vector in flag layout.
    always_comb begin
        ovf_vec              = '0;
        ovf_vec[NUM_EVT-1:0] = evt_ovf;
        ovf_vec[CYC_BIT]     = cyc_long ? cyc_wrap64 : cyc_wrap32;
        if (HAS_INSTR != 0) ovf_vec[INS_BIT] = ins_wrap64;
    end
endmodule

// File: rtl/ovf_acc_gate.sv
// Module: ovf_acc_gate
// Decides whether a bus access is blocked. Builds the mask of bits that
// exist and the mask of bits this caller may see and write.
// Assumes rr_bound counts event counters; the cycle and instruction
// flags are never restricted.
module ovf_acc_gate
    import ovf_pkg::*;
#(
    parameter int NUM_EVT   = 6,
    parameter int HAS_INSTR = 1
) (
    input  logic             core_off,
    input  logic             dbl_lock,
    input  logic             ext_block,
    input  logic             os_lock,
    input  logic             os_override,
    input  logic             rr_en,
    input  logic [IDX_W-1:0] rr_bound,
    input  logic             acc_secure,
    output logic             acc_err,
    output logic [REG_W-1:0] impl_mask,
    output logic [REG_W-1:0] vis_mask
);
    logic restrict_now;

    // Error when any blocking condition holds.
    assign acc_err      = core_off | dbl_lock | ext_block | (os_lock & ~os_override);
    assign restrict_now = rr_en & ~acc_secure;

    // Built bits and caller-visible bits, one generate slice per position.
    for (genvar b = 0; b < REG_W; b++) begin : g_mask
        if (b < NUM_EVT) begin : g_evt
            assign impl_mask[b] = 1'b1;
            assign vis_mask[b]  = ~(restrict_now & (IDX_W'(b) >= rr_bound));
        end else if (b == CYC_BIT || (b == INS_BIT && HAS_INSTR != 0)) begin : g_fix
            assign impl_mask[b] = 1'b1;
            assign vis_mask[b]  = 1'b1;
        end else begin : g_none
            assign impl_mask[b] = 1'b0;
            assign vis_mask[b]  = 1'b0;
        end
    end
endmodule

// File: rtl/ovf_flag_store.sv
// Module: ovf_flag_store
// Holds the sticky flags. Each cycle it applies set and clear masks,
// then ORs in overflows so that an overflow wins over a clear. Bits
// outside impl_mask are held at zero.
module ovf_flag_store
    import ovf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] impl_mask,
    input  logic [REG_W-1:0] set_w,
    input  logic [REG_W-1:0] clr_w,
    input  logic [REG_W-1:0] ovf_vec,
    output logic [REG_W-1:0] flags_q
);
    logic [REG_W-1:0] flags_d;

    // Next state: software set, software clear, then overflow on top.
    assign flags_d = (((flags_q | set_w) & ~clr_w) | ovf_vec) & impl_mask;

    // Flag register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    // R6: a flag that was not cleared last cycle is still set.
    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(flags_q) & ~$past(clr_w) & ~flags_q) == '0));

    // R8: every overflow of last cycle shows in the flags, whatever the clear.
    assert_ovf_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(ovf_vec & impl_mask) & ~flags_q) == '0));
endmodule

// File: rtl/ovf_flag_reg.sv
// Module: ovf_flag_reg (top)
// Overflow flag status register. It joins overflow detection, access
// gating and flag storage, and returns a registered one-cycle response
// for each bus access. Assumes at most one access per cycle.
module ovf_flag_reg
    import ovf_pkg::*;
#(
    parameter int NUM_EVT   = 6,
    parameter int HAS_INSTR = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cyc_long,
    input  logic               evt_long_lo,
    input  logic               evt_long_hi,
    input  logic [4:0]         evt_split,
    input  logic               cyc_wrap32,
    input  logic               cyc_wrap64,
    input  logic [NUM_EVT-1:0] evt_wrap32,
    input  logic [NUM_EVT-1:0] evt_wrap64,
    input  logic               ins_wrap64,
    input  logic               rr_en,
    input  logic [4:0]         rr_bound,
    input  logic               acc_secure,
    input  logic               core_off,
    input  logic               dbl_lock,
    input  logic               ext_block,
    input  logic               os_lock,
    input  logic               os_override,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [1:0]         bus_view,
    input  logic [63:0]        bus_wdata,
    output logic               rsp_vld,
    output logic               rsp_err,
    output logic [63:0]        rsp_rdata
);
    logic [REG_W-1:0] ovf_vec, impl_mask, vis_mask, flags_q, set_w, clr_w;
    logic             acc_err, wr_ok;
    view_e            view;

    ovf_detect #(.NUM_EVT(NUM_EVT), .HAS_INSTR(HAS_INSTR)) u_detect (
        .cyc_long(cyc_long), .evt_long_lo(evt_long_lo), .evt_long_hi(evt_long_hi),
        .evt_split(evt_split), .cyc_wrap32(cyc_wrap32), .cyc_wrap64(cyc_wrap64),
        .evt_wrap32(evt_wrap32), .evt_wrap64(evt_wrap64), .ins_wrap64(ins_wrap64),
        .ovf_vec(ovf_vec)
    );

    ovf_acc_gate #(.NUM_EVT(NUM_EVT), .HAS_INSTR(HAS_INSTR)) u_gate (
        .core_off(core_off), .dbl_lock(dbl_lock), .ext_block(ext_block),
        .os_lock(os_lock), .os_override(os_override), .rr_en(rr_en),
        .rr_bound(rr_bound), .acc_secure(acc_secure), .acc_err(acc_err),
        .impl_mask(impl_mask), .vis_mask(vis_mask)
    );

    // Write decode: only a permitted write to the set or clear view counts.
    assign view  = view_e'(bus_view);
    assign wr_ok = bus_sel & bus_wr & ~acc_err;
    assign set_w = (wr_ok && view == VIEW_SET) ? (bus_wdata & vis_mask) : '0;
    assign clr_w = (wr_ok && view == VIEW_CLR) ? (bus_wdata & vis_mask) : '0;

    ovf_flag_store u_store (
        .clk(clk), .rst_n(rst_n), .impl_mask(impl_mask), .set_w(set_w),
        .clr_w(clr_w), .ovf_vec(ovf_vec), .flags_q(flags_q)
    );

    // Registered response carrying the pre-write visible flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld   <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_vld   <= bus_sel;
            rsp_err   <= bus_sel & acc_err;
            rsp_rdata <= (bus_sel && !acc_err) ? (flags_q & vis_mask) : '0;
        end
    end

    // R12: every access gets a response on the next cycle.
    assert_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel |=> rsp_vld);

    // R3: a selected long cycle wrap sets the cycle flag.
    assert_cyc_long_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_long && cyc_wrap64) |=> flags_q[CYC_BIT]);

    // R11: a blocked access clears no flag.
    assert_err_nowrite_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && acc_err) |=> (($past(flags_q) & ~flags_q) == '0));

    // R5: the instruction counter wrap sets bit 32.
    if (HAS_INSTR != 0) begin : g_ins_chk
        assert_ins_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ins_wrap64 |=> flags_q[INS_BIT]);
    end
endmodule

// File: tb/tb_ovf_flag_reg.sv
// Scoreboard bench: the driver task predicts each response into a queue;
// a monitor pops and compares at every rsp_vld.
module tb_ovf_flag_reg;
    localparam int NUM_EVT   = 6;
    localparam int HAS_INSTR = 1;

    typedef struct {
        logic [63:0] rdata;
        logic        err;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_long = 0, evt_long_lo = 0, evt_long_hi = 0;
    logic [4:0] evt_split = 5'd0, rr_bound = 5'd0;
    logic cyc_wrap32 = 0, cyc_wrap64 = 0, ins_wrap64 = 0;
    logic [NUM_EVT-1:0] evt_wrap32 = '0, evt_wrap64 = '0;
    logic rr_en = 0, acc_secure = 1, core_off = 0, dbl_lock = 0, ext_block = 0;
    logic os_lock = 0, os_override = 0;
    logic bus_sel = 0, bus_wr = 0;
    logic [1:0] bus_view = 2'b00;
    logic [63:0] bus_wdata = '0;
    logic rsp_vld, rsp_err;
    logic [63:0] rsp_rdata;

    exp_t        sb[$];
    logic [63:0] model = '0;
    int          n_chk = 0, n_fail = 0;
    bit          done = 0;

    always #4 clk = ~clk;

    ovf_flag_reg #(.NUM_EVT(NUM_EVT), .HAS_INSTR(HAS_INSTR)) dut (
        .clk(clk), .rst_n(rst_n), .cyc_long(cyc_long), .evt_long_lo(evt_long_lo),
        .evt_long_hi(evt_long_hi), .evt_split(evt_split), .cyc_wrap32(cyc_wrap32),
        .cyc_wrap64(cyc_wrap64), .evt_wrap32(evt_wrap32), .evt_wrap64(evt_wrap64),
        .ins_wrap64(ins_wrap64), .rr_en(rr_en), .rr_bound(rr_bound),
        .acc_secure(acc_secure), .core_off(core_off), .dbl_lock(dbl_lock),
        .ext_block(ext_block), .os_lock(os_lock), .os_override(os_override),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_view(bus_view), .bus_wdata(bus_wdata),
        .rsp_vld(rsp_vld), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    // Bits that exist (R2, R9).
    function automatic logic [63:0] exist_bits();
        logic [63:0] v = '0;
        for (int m = 0; m < NUM_EVT; m++) v[m] = 1'b1;
        v[31] = 1'b1;
        if (HAS_INSTR != 0) v[32] = 1'b1;
        return v;
    endfunction

    // Bits this caller may see (R10).
    function automatic logic [63:0] seen_bits();
        logic [63:0] v = exist_bits();
        if (rr_en && !acc_secure)
            for (int m = 0; m < NUM_EVT; m++) if (m >= int'(rr_bound)) v[m] = 1'b0;
        return v;
    endfunction

    // Overflows the current pulses and modes should raise (R3, R4, R5).
    function automatic logic [63:0] exp_ovf();
        logic [63:0] v = '0;
        v[31] = cyc_long ? cyc_wrap64 : cyc_wrap32;
        for (int m = 0; m < NUM_EVT; m++) begin
            logic lg = (m >= int'(evt_split)) ? evt_long_hi : evt_long_lo;
            v[m] = lg ? evt_wrap64[m] : evt_wrap32[m];
        end
        if (HAS_INSTR != 0) v[32] = ins_wrap64;
        return v;
    endfunction

    // One cycle: optional access plus whatever pulses are set; predicts and updates the model.
    task automatic step(input logic acc, input logic [1:0] view, input logic wr,
                        input logic [63:0] data, input string tag);
        logic        err;
        logic [63:0] m;
        exp_t        e;
        err = core_off | dbl_lock | ext_block | (os_lock & ~os_override);
        bus_sel = acc; bus_view = view; bus_wr = wr; bus_wdata = data;
        m = model;
        if (acc) begin
            e.rdata = err ? 64'h0 : (model & seen_bits());
            e.err   = err;
            e.tag   = tag;
            sb.push_back(e);
            if (!err && wr && view == 2'b01) m = m | (data & seen_bits());
            if (!err && wr && view == 2'b10) m = m & ~(data & seen_bits());
        end
        model = (m | exp_ovf()) & exist_bits();
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_wdata = '0;
        cyc_wrap32 = 0; cyc_wrap64 = 0; ins_wrap64 = 0;
        evt_wrap32 = '0; evt_wrap64 = '0;
    endtask

    task automatic rd(input string tag);
        step(1'b1, 2'b00, 1'b0, 64'h0, tag);
    endtask

    task automatic wr_view(input logic [1:0] v, input logic [63:0] d, input string tag);
        step(1'b1, v, 1'b1, d, tag);
    endtask

    // Monitor: compare each response with the oldest prediction.
    always @(negedge clk) begin
        if (rst_n && rsp_vld) begin
            exp_t e;
            n_chk++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL R12: unexpected response rdata=%h err=%b expected no response",
                         rsp_rdata, rsp_err);
            end else begin
                e = sb.pop_front();
                if (rsp_rdata !== e.rdata || rsp_err !== e.err) begin
                    n_fail++;
                    $display("FAIL %s: rdata=%h err=%b expected rdata=%h err=%b",
                             e.tag, rsp_rdata, rsp_err, e.rdata, e.err);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd("R1 reset value");

        // R3: cycle flag pulse selection, both modes.
        cyc_long = 0; cyc_wrap64 = 1; step(0, 0, 0, 0, "");
        rd("R3 short mode ignores 64-bit wrap");
        cyc_wrap32 = 1; step(0, 0, 0, 0, "");
        rd("R3 short mode sets on 32-bit wrap");
        wr_view(2'b10, 64'hFFFF_FFFF_FFFF_FFFF, "R7 clear all");
        cyc_long = 1; cyc_wrap32 = 1; step(0, 0, 0, 0, "");
        rd("R3 long mode ignores 32-bit wrap");
        cyc_wrap64 = 1; step(0, 0, 0, 0, "");
        rd("R3 long mode sets on 64-bit wrap");

        // R4: split between lo and hi controls.
        evt_split = 5'd3; evt_long_lo = 0; evt_long_hi = 1;
        evt_wrap32 = '1; step(0, 0, 0, 0, "");
        rd("R4 32-bit wraps set only counters below split");
        wr_view(2'b10, 64'hFFFF_FFFF_FFFF_FFFF, "R7 clear before 64-bit event case");
        evt_wrap64 = '1; step(0, 0, 0, 0, "");
        rd("R4 64-bit wraps set only counters at or above split");

        // R5: instruction counter.
        ins_wrap64 = 1; step(0, 0, 0, 0, "");
        rd("R5 instruction wrap sets bit 32");

        // R6: stickiness over idle cycles.
        repeat (5) step(0, 0, 0, 0, "");
        rd("R6 flags held after idle cycles");

        // R7, R9, R2: views and existing bits.
        wr_view(2'b10, 64'hFFFF_FFFF_FFFF_FFFF, "R7 clear view");
        wr_view(2'b00, 64'hFFFF_FFFF_FFFF_FFFF, "R7 read view write ignored");
        wr_view(2'b11, 64'hFFFF_FFFF_FFFF_FFFF, "R7 reserved view write ignored");
        rd("R7 still clear after ignored writes");
        wr_view(2'b01, 64'hFFFF_FFFF_FFFF_FFFF, "R7 set view");
        rd("R9 R2 only built bits set");
        wr_view(2'b10, 64'h0000_0000_0000_0005, "R7 clear selected bits");
        rd("R7 clear view removed only written ones");

        // R8: overflow beats clear on bit 0.
        wr_view(2'b01, 64'h1, "R8 prepare bit 0");
        evt_wrap32 = 6'b000001; evt_long_lo = 0;
        wr_view(2'b10, 64'h1, "R8 clear with overflow");
        rd("R8 overflow kept the flag");

        // R10: restricted range.
        wr_view(2'b01, 64'hFFFF_FFFF_FFFF_FFFF, "R10 fill");
        rr_en = 1; rr_bound = 5'd2; acc_secure = 0;
        rd("R10 non-secure sees only low counters");
        wr_view(2'b10, 64'hFFFF_FFFF_FFFF_FFFF, "R10 non-secure clear");
        acc_secure = 1;
        rd("R10 secure sees hidden flags untouched");
        acc_secure = 0;
        wr_view(2'b01, 64'hFFFF_FFFF_FFFF_FFFF, "R10 non-secure set");
        acc_secure = 1; rr_en = 0;
        rd("R10 state after non-secure set");

        // R11: error causes.
        core_off = 1;
        wr_view(2'b10, 64'hFFFF_FFFF_FFFF_FFFF, "R11 core off");
        core_off = 0; dbl_lock = 1;
        wr_view(2'b10, 64'hFFFF_FFFF_FFFF_FFFF, "R11 double lock");
        dbl_lock = 0; ext_block = 1;
        rd("R11 external blocked");
        ext_block = 0; os_lock = 1;
        wr_view(2'b10, 64'hFFFF_FFFF_FFFF_FFFF, "R11 os lock");
        cyc_wrap64 = 1; cyc_long = 1;
        rd("R11 overflow during error access");
        os_override = 1;
        rd("R11 os lock with override allowed");
        os_lock = 0; os_override = 0;
        rd("R11 flags unchanged by errored writes");

        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL R12: %0d responses missing expected 0", sb.size());
        end
        done = 1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule